// File: doc/BRIEF.md
# Down-Counting Event Timer with Register Bus

A single-channel event timer for a processor subsystem. Software programs a reload value through a 32-bit register bus, then sets the run bit. From then on the counter steps down by one on every clock. When it reaches zero it raises an interrupt. In single-pass mode the counter then stays at zero. In repeating mode it reloads and counts again, so it gives a steady tick. The counter is 64 bits wide, and a control bit limits it to its low 32 bits.

The intended programming order is: clear the run bit, write the low word of the reload value, write the high word, then write the control register with the run bit set and the chosen mode bits. The interrupt has its own enable bit, a raw flag and a gated flag, and a self-clearing acknowledge bit. A pair of snapshot registers lets software read the full 64-bit count in two bus reads without the halves tearing. Reading the low snapshot word captures the upper half, and the high snapshot word returns that capture. The bus takes one read or one write per cycle, and read data is valid in the same cycle as the address.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped, and `irq_o` is low.
- R2: A control write (offset 0x10) that sets bit 1 while the run bit is 0 loads the counter from the reload words, which sit at offset 0x00 (low) and 0x04 (high). After that the counter falls by exactly one per clock while running and nonzero. Offset 0x08 reads the low half of the live count and offset 0x0C reads the high half.
- R3: The clock edge on which the count goes from 1 to 0 sets the raw flag, which is bit 1 of offset 0x14.
- R4: With bit 0 of the control register clear (single pass), the count stays at 0 after it expires until the run bit is cleared and set again.
- R5: With control bit 0 set (repeating), the edge that expires the count loads the current reload value, so the count never rests at 0 and expiries recur every reload-value clocks.
- R6: With control bit 16 clear (32-bit width), offset 0x0C reads 0 and the high reload word has no effect on the count.
- R7: Bit 2 of offset 0x14 reads raw flag AND enable, where the enable is bit 0 of offset 0x14. `irq_o` follows bit 2.
- R8: Writing offset 0x14 with bit 3 set clears the raw flag and stores bit 0 as the enable. Bit 3 always reads 0. If an expiry happens on the same edge, the raw flag stays set.
- R9: While the run bit is 0 the count holds its value and no expiry occurs.
- R10: A read of offset 0x18 returns the live low half and captures the live high half. Offset 0x1C returns the captured value until the next read of 0x18.
- R11: A reload value of 0 never produces an expiry.
- R12: The control register reads back only bits 0, 1 and 16, with every other bit 0. The reload words read back as written. Writes to offsets 0x08, 0x0C, 0x18 and 0x1C change nothing, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used for the snapshot capture |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq_o | output | 1 | Interrupt request, equal to the gated flag |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands on the very edge where the count expires, since the bench must hit one exact cycle through bus writes. The stimulus repeats a short single-pass run with a reload of 3 and slides the acknowledge write one cycle later on each pass. One pass therefore collides with the expiry, and the bench checks that the raw flag survives there. The tear-free snapshot is reached with a 64-bit reload of 0x1_00000001, so the high half changes two clocks after the start. The bench then compares the captured high half against the live one.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;
    localparam int TMR_DW = 32;
    localparam int TMR_AW = 5;

    // register byte offsets
    localparam int OFS_LOAD_LO = 'h00;
    localparam int OFS_LOAD_HI = 'h04;
    localparam int OFS_VAL_LO  = 'h08;
    localparam int OFS_VAL_HI  = 'h0C;
    localparam int OFS_CTL     = 'h10;
    localparam int OFS_INT     = 'h14;
    localparam int OFS_SNAP_LO = 'h18;
    localparam int OFS_SNAP_HI = 'h1C;

    // control bit positions
    localparam int CTL_PER_BIT  = 0;
    localparam int CTL_RUN_BIT  = 1;
    localparam int CTL_WIDE_BIT = 16;

    // interrupt register bit positions
    localparam int INT_EN_BIT  = 0;
    localparam int INT_RAW_BIT = 1;
    localparam int INT_MSK_BIT = 2;
    localparam int INT_ACK_BIT = 3;

    typedef struct packed {
        logic wide;
        logic run;
        logic per;
    } tmr_ctl_t;
endpackage

// File: rtl/evt_timer_regs.sv
`timescale 1ns/1ps
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int DW = TMR_DW,
    parameter int AW = TMR_AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            expire,
    output logic [DW-1:0]   load_lo,
    output logic [DW-1:0]   load_hi,
    output tmr_ctl_t        ctl,
    output tmr_ctl_t        ctl_nx,
    output logic            ien,
    output logic            raw,
    output logic            start,
    output logic [2*DW-1:0] start_val,
    output logic [2*DW-1:0] reload_val
);
    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        tmr_ctl_t      ctl;
        logic          ien;
        logic          raw;
    } regs_t;

    regs_t s_d, s_q;
    logic  wr_lo, wr_hi, wr_ctl, wr_int;

    always_comb begin
        wr_lo  = wr_en && (addr == AW'(OFS_LOAD_LO));
        wr_hi  = wr_en && (addr == AW'(OFS_LOAD_HI));
        wr_ctl = wr_en && (addr == AW'(OFS_CTL));
        wr_int = wr_en && (addr == AW'(OFS_INT));

        s_d = s_q;
        if (wr_lo) s_d.lo = wdata;
        if (wr_hi) s_d.hi = wdata;
        if (wr_ctl) begin
            s_d.ctl.wide = wdata[CTL_WIDE_BIT];
            s_d.ctl.run  = wdata[CTL_RUN_BIT];
            s_d.ctl.per  = wdata[CTL_PER_BIT];
        end
        if (wr_int) s_d.ien = wdata[INT_EN_BIT];
        // a new expiry outranks an acknowledge on the same edge
        if (expire)
            s_d.raw = 1'b1;
        else if (wr_int && wdata[INT_ACK_BIT])
            s_d.raw = 1'b0;

        start      = wr_ctl && wdata[CTL_RUN_BIT] && !s_q.ctl.run;
        start_val  = s_d.ctl.wide ? {s_q.hi, s_q.lo} : {{DW{1'b0}}, s_q.lo};
        reload_val = s_q.ctl.wide ? {s_q.hi, s_q.lo} : {{DW{1'b0}}, s_q.lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign load_lo = s_q.lo;
    assign load_hi = s_q.hi;
    assign ctl     = s_q.ctl;
    assign ctl_nx  = s_d.ctl;
    assign ien     = s_q.ien;
    assign raw     = s_q.raw;
endmodule

// File: rtl/evt_timer_core.sv
`timescale 1ns/1ps
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter int CW = 2 * TMR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_ctl_t      ctl,
    input  tmr_ctl_t      ctl_nx,
    input  logic          start,
    input  logic [CW-1:0] start_val,
    input  logic [CW-1:0] reload_val,
    output logic [CW-1:0] cnt,
    output logic          expire
);
    localparam int HW = CW / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        expire = 1'b0;
        if (start) begin
            c_d.cnt = start_val;
        end else if (ctl.run && (c_q.cnt != '0)) begin
            if (c_q.cnt == CW'(1)) begin
                expire  = 1'b1;
                c_d.cnt = ctl.per ? reload_val : '0;
            end else begin
                c_d.cnt = c_q.cnt - CW'(1);
            end
        end
        if (!ctl_nx.wide) c_d.cnt[CW-1:HW] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.cnt;
endmodule

// File: rtl/evt_timer_snap.sv
`timescale 1ns/1ps
module evt_timer_snap
    import evt_timer_pkg::*;
#(
    parameter int DW = TMR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          snap,
    input  logic [DW-1:0] hi_in,
    output logic [DW-1:0] hi_q
);
    typedef struct packed {
        logic [DW-1:0] hi;
    } snap_t;

    snap_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (snap) h_d.hi = hi_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign hi_q = h_q.hi;
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int DW = TMR_DW,
    parameter int AW = TMR_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);
    localparam int CW = 2 * DW;

    logic [DW-1:0] load_lo, load_hi, snap_hi;
    logic [CW-1:0] start_val, reload_val, cnt;
    tmr_ctl_t      ctl, ctl_nx;
    logic          ien, raw, start, expire, masked, snap;

    evt_timer_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .expire(expire), .load_lo(load_lo),
        .load_hi(load_hi), .ctl(ctl), .ctl_nx(ctl_nx), .ien(ien),
        .raw(raw), .start(start), .start_val(start_val),
        .reload_val(reload_val)
    );

    evt_timer_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .ctl_nx(ctl_nx),
        .start(start), .start_val(start_val), .reload_val(reload_val),
        .cnt(cnt), .expire(expire)
    );

    assign snap = bus_rd && (bus_addr == AW'(OFS_SNAP_LO));

    evt_timer_snap #(.DW(DW)) u_snap (
        .clk(clk), .rst_n(rst_n), .snap(snap),
        .hi_in(cnt[CW-1:DW]), .hi_q(snap_hi)
    );

    assign masked = raw & ien;
    assign irq_o  = masked;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_LOAD_LO)) bus_rdata = load_lo;
        if (bus_addr == AW'(OFS_LOAD_HI)) bus_rdata = load_hi;
        if (bus_addr == AW'(OFS_VAL_LO))  bus_rdata = cnt[DW-1:0];
        if (bus_addr == AW'(OFS_VAL_HI))  bus_rdata = cnt[CW-1:DW];
        if (bus_addr == AW'(OFS_CTL)) begin
            bus_rdata[CTL_PER_BIT]  = ctl.per;
            bus_rdata[CTL_RUN_BIT]  = ctl.run;
            bus_rdata[CTL_WIDE_BIT] = ctl.wide;
        end
        if (bus_addr == AW'(OFS_INT)) begin
            bus_rdata[INT_EN_BIT]  = ien;
            bus_rdata[INT_RAW_BIT] = raw;
            bus_rdata[INT_MSK_BIT] = masked;
        end
        if (bus_addr == AW'(OFS_SNAP_LO)) bus_rdata = cnt[DW-1:0];
        if (bus_addr == AW'(OFS_SNAP_HI)) bus_rdata = snap_hi;
    end
endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int CW = 2 * TMR_DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_o,
    input logic [CW-1:0] cnt,
    input tmr_ctl_t      ctl,
    input tmr_ctl_t      ctl_nx,
    input logic          start,
    input logic          expire,
    input logic          raw,
    input logic          ien
);
    localparam int HW = CW / 2;

    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.run && !start && cnt > CW'(1) && ctl_nx.wide == ctl.wide)
        |=> cnt == $past(cnt) - CW'(1));

    assert_raw_on_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw);

    assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.run && !ctl.per && cnt == '0) |=> cnt == '0);

    assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.wide |-> cnt[CW-1:HW] == '0);

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ien && raw));

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.run && !start && (ctl_nx.wide || !ctl.wide)) |=> $stable(cnt));

    assert_stopped_no_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.run |-> !expire);
endmodule

bind evt_timer evt_timer_chk #(.CW(2 * DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .cnt(cnt), .ctl(ctl),
    .ctl_nx(ctl_nx), .start(start), .expire(expire), .raw(raw), .ien(ien)
);

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    evt_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference ----------------
    logic [31:0] m_lo = 0, m_hi = 0, m_snap = 0;
    logic [63:0] m_cnt = 0, nc;
    bit m_per = 0, m_run = 0, m_wide = 0, m_ien = 0, m_raw = 0;
    bit wc, wi, np, nr, nw, ex;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_snap = 0; m_cnt = 0;
            m_per = 0; m_run = 0; m_wide = 0; m_ien = 0; m_raw = 0;
        end else begin
            wc = bus_wr && bus_addr == 5'h10;
            wi = bus_wr && bus_addr == 5'h14;
            np = wc ? bus_wdata[0]  : m_per;
            nr = wc ? bus_wdata[1]  : m_run;
            nw = wc ? bus_wdata[16] : m_wide;
            ex = 0;
            nc = m_cnt;
            if (wc && bus_wdata[1] && !m_run)
                nc = nw ? {m_hi, m_lo} : {32'd0, m_lo};
            else if (m_run && m_cnt != 0) begin
                if (m_cnt == 1) begin
                    ex = 1;
                    nc = m_per ? (m_wide ? {m_hi, m_lo} : {32'd0, m_lo}) : 64'd0;
                end else nc = m_cnt - 1;
            end
            if (!nw) nc[63:32] = 0;
            if (bus_rd && bus_addr == 5'h18) m_snap = m_cnt[63:32];
            if (ex) m_raw = 1;
            else if (wi && bus_wdata[3]) m_raw = 0;
            if (wi) m_ien = bus_wdata[0];
            if (bus_wr && bus_addr == 5'h00) m_lo = bus_wdata;
            if (bus_wr && bus_addr == 5'h04) m_hi = bus_wdata;
            m_per = np; m_run = nr; m_wide = nw; m_cnt = nc;
        end
    end

    function automatic logic [31:0] model_read(input logic [4:0] a);
        case (a)
            5'h00: return m_lo;
            5'h04: return m_hi;
            5'h08: return m_cnt[31:0];
            5'h0C: return m_cnt[63:32];
            5'h10: return {15'd0, m_wide, 14'd0, m_run, m_per};
            5'h14: return {29'd0, m_raw & m_ien, m_raw, m_ien};
            5'h18: return m_cnt[31:0];
            5'h1C: return m_snap;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'h08, 5'h0C: return "R2";
            5'h14:        return "R7";
            5'h18, 5'h1C: return "R10";
            default:      return "R12";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // compare against the reference every clock, mid-cycle
    always @(negedge clk) begin
        if (!done) begin
            check(irq_o == (m_raw & m_ien), "R7", "irq_o per-clock",
                  64'(irq_o), 64'(m_raw & m_ien));
            check(bus_rdata == model_read(bus_addr), tag_of(bus_addr),
                  "rdata per-clock", 64'(bus_rdata), 64'(model_read(bus_addr)));
        end
    end

    // ---------------- bus tasks (start and end at posedge+1) ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        #3;
        d = bus_rdata;
        tick();
        bus_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        finish_run();
    end

    logic [31:0] v, v2;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v);
            check(v == 0, "R1", "reset read", 64'(v), 64'd0);
        end
        rd(5'h14, v);
        check(irq_o == 0, "R1", "irq after reset", 64'(irq_o), 64'd0);
        rst_n = 1;
        tick();

        // R2/R3/R4/R6: single pass, narrow, high word ignored
        wr(5'h10, 32'h0);
        wr(5'h00, 32'd100);
        wr(5'h04, 32'h55);
        wr(5'h14, 32'h1);
        wr(5'h10, 32'h2);
        rd(5'h08, v);
        check(v == 100, "R2", "count after start", 64'(v), 64'd100);
        idle(9);
        rd(5'h08, v);
        check(v == 90, "R2", "count after 10 clocks", 64'(v), 64'd90);
        rd(5'h0C, v);
        check(v == 0, "R6", "narrow high half", 64'(v), 64'd0);
        idle(100);
        rd(5'h08, v);
        check(v == 0, "R4", "single pass holds zero", 64'(v), 64'd0);
        rd(5'h14, v);
        check(v == 32'h7, "R3", "raw and masked set", 64'(v), 64'h7);
        check(irq_o == 1, "R7", "irq asserted", 64'(irq_o), 64'd1);
        wr(5'h14, 32'h9);
        rd(5'h14, v);
        check(v == 32'h1, "R8", "ack clears raw keeps enable", 64'(v), 64'h1);
        check(irq_o == 0, "R8", "irq dropped after ack", 64'(irq_o), 64'd0);
        idle(5);
        rd(5'h08, v);
        check(v == 0, "R4", "still zero", 64'(v), 64'd0);

        // R5: repeating mode never rests at zero
        wr(5'h10, 32'h0);
        wr(5'h00, 32'd4);
        wr(5'h10, 32'h3);
        for (int i = 0; i < 12; i++) begin
            rd(5'h08, v);
            check(v != 0, "R5", "repeating count nonzero", 64'(v), 64'd1);
        end
        rd(5'h14, v);
        check(v[1] == 1, "R5", "repeating expiry raised", 64'(v[1]), 64'd1);
        wr(5'h14, 32'h8);
        check(irq_o == 0, "R7", "irq gated by enable 0", 64'(irq_o), 64'd0);
        idle(8);
        rd(5'h14, v);
        check(v == 32'h2, "R7", "raw without masked", 64'(v), 64'h2);

        // R9: stopping freezes the count
        wr(5'h10, 32'h1);
        rd(5'h08, v);
        idle(6);
        rd(5'h08, v2);
        check(v == v2, "R9", "frozen count", 64'(v2), 64'(v));
        // R12: read-only offsets ignore writes
        wr(5'h08, 32'h1234);
        wr(5'h18, 32'h1234);
        rd(5'h08, v2);
        check(v == v2, "R12", "value ignores write", 64'(v2), 64'(v));
        wr(5'h10, 32'hFFFE_FFFC);
        rd(5'h10, v);
        check(v == 0, "R12", "reserved ctl bits", 64'(v), 64'd0);

        // R6 wide + R10 snapshot
        wr(5'h00, 32'd1);
        wr(5'h04, 32'd1);
        wr(5'h10, 32'h0001_0002);
        rd(5'h18, v);
        check(v == 1, "R10", "snapshot low live", 64'(v), 64'd1);
        idle(3);
        rd(5'h0C, v);
        check(v == 0, "R6", "wide high half rolled", 64'(v), 64'd0);
        rd(5'h1C, v);
        check(v == 1, "R10", "snapshot high held", 64'(v), 64'd1);
        rd(5'h10, v);
        check(v == 32'h0001_0002, "R12", "ctl readback", 64'(v), 64'h0001_0002);

        // R11: zero reload never expires
        wr(5'h10, 32'h0);
        wr(5'h14, 32'h9);
        wr(5'h00, 32'd0);
        wr(5'h10, 32'h3);
        idle(10);
        rd(5'h14, v);
        check(v == 32'h1, "R11", "zero reload no expiry", 64'(v), 64'h1);

        // R8: sweep the ack across the expiry edge
        for (int d = 0; d < 6; d++) begin
            wr(5'h10, 32'h0);
            wr(5'h14, 32'h9);
            wr(5'h00, 32'd3);
            wr(5'h10, 32'h2);
            idle(d);
            wr(5'h14, 32'h9);
            rd(5'h14, v);
            if (d == 2)
                check(v == 32'h7, "R8", "expiry beats ack", 64'(v), 64'h7);
            if (d == 0)
                check(v == 32'h1, "R8", "early ack no raw", 64'(v), 64'h1);
            idle(4);
        end

        finish_run();
    end
endmodule